// File: doc/BRIEF.md
# Wrap-Inferring Timestamp Extender

This block turns a narrow free-running counter into a wide, monotonic timestamp. The counter itself lives elsewhere, in the same clock domain. The extender only looks at the counter when it is told to sample it. Strobes come from two sources: a periodic tick, which keeps wraps from being missed, and a timestamp read request.

There is no carry input. On each sample the block compares the new value with the one it kept from the previous sample. If the stored value is strictly larger, the counter has wrapped and the upper word advances by one.

The wrap check and the composed result use the same sampled value. The order within one update is fixed: take the sample, adjust the upper word, then build the output. The composed value is registered and comes out one cycle after the strobe, together with a single-cycle valid pulse.

The counter must be sampled at least once per wrap period. While the counter source is not yet marked as initialised (`armed_i` low), a sample reads as zero.

Top module: `ctr_extend`

## Requirements
- R1: One cycle after a strobe, `ts_valid_o` is high for exactly one cycle, and `ts_o` equals the upper word (after this sample's update) concatenated above the sampled low value.
- R2: If a previous sample exists and is strictly greater than the current sample, the upper word increases by exactly one.
- R3: A current sample equal to or greater than the previous one leaves the upper word unchanged.
- R4: After reset, `ts_o` is 0 and `ts_valid_o` is 0. The first sample after reset never advances the upper word.
- R5: Every sample, wrapping or not, replaces the stored previous value and marks it as present.
- R6: A tick strobe and a read strobe in the same cycle form one update: at most one increment and one valid pulse.
- R7: While `armed_i` is 0, a strobe samples the value 0 instead of `cnt_i`, so the low word of `ts_o` is 0 and the stored previous value becomes 0.
- R8: In a cycle with no strobe, the upper word, the stored sample and `ts_o` hold, and `ts_valid_o` is 0.
- R9: The upper word counts modulo 2^HI_W. An increment from its maximum value gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | LO_W | Free-running counter value |
| armed_i | input | 1 | Counter source initialised; when 0, samples read as zero |
| tick_i | input | 1 | Periodic sample strobe |
| read_i | input | 1 | Timestamp read strobe |
| ts_o | output | LO_W+HI_W | Composed timestamp {upper, low} |
| ts_valid_o | output | 1 | One-cycle pulse marking a fresh `ts_o` |

## Verification
The bench builds the extender with LO_W=4 and HI_W=4. At that size every ordered pair of low values can be applied back to back in one continuous run, so each greater, equal and smaller transition occurs, including the 15-to-0 wrap and the 0-to-15 forward step. With 16 upper-word values, the upper word also passes through its own modulo wrap several times during the sweep. Merged strobes, unarmed samples and the first sample after a reset are placed between sweeps to exercise R4, R6 and R7.

// File: rtl/ctr_extend_pkg.sv
package ctr_extend_pkg;
  localparam int MAXW = 64;

  // Wrap inferred when a previous sample exists and exceeds the current one.
  function automatic logic is_wrap(logic [MAXW-1:0] prev, logic [MAXW-1:0] cur, logic have_prev);
    return have_prev && (prev > cur);
  endfunction

  function automatic logic [MAXW-1:0] bump(logic [MAXW-1:0] hi, logic inc);
    return hi + {{(MAXW-1){1'b0}}, inc};
  endfunction
endpackage

// File: rtl/ctr_extend_strobe.sv
module ctr_extend_strobe #(
  parameter int LO_W  = 32,
  parameter int N_SRC = 2
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic             armed_i,
  input  logic [LO_W-1:0]  cnt_i,
  output logic             strobe_o,
  output logic [LO_W-1:0]  sample_o
);
  logic [N_SRC:0] any_w;
  assign any_w[0] = 1'b0;

  for (genvar g = 0; g < N_SRC; g++) begin : g_or
    assign any_w[g+1] = any_w[g] | src_i[g];
  end

  assign strobe_o = any_w[N_SRC];
  assign sample_o = armed_i ? cnt_i : '0;
endmodule

// File: rtl/ctr_extend_wrap.sv
module ctr_extend_wrap
  import ctr_extend_pkg::*;
#(
  parameter int LO_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  logic [LO_W-1:0] sample_i,
  output logic            wrap_o
);
  logic [LO_W-1:0] prev_q;
  logic            have_prev_q;

  assign wrap_o = strobe_i && is_wrap(MAXW'(prev_q), MAXW'(sample_i), have_prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q      <= '0;
      have_prev_q <= 1'b0;
    end else if (strobe_i) begin
      prev_q      <= sample_i;
      have_prev_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ctr_extend_high.sv
module ctr_extend_high
  import ctr_extend_pkg::*;
#(
  parameter int HI_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrap_i,
  output logic [HI_W-1:0] hi_q_o,
  output logic [HI_W-1:0] hi_next_o
);
  logic [HI_W-1:0] hi_q;
  logic [MAXW-1:0] wide_w;

  assign wide_w    = bump(MAXW'(hi_q), wrap_i);
  assign hi_next_o = wide_w[HI_W-1:0];
  assign hi_q_o    = hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_q <= '0;
    else        hi_q <= hi_next_o;
  end
endmodule

// File: rtl/ctr_extend.sv
module ctr_extend #(
  parameter int LO_W = 32,
  parameter int HI_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LO_W-1:0]      cnt_i,
  input  logic                 armed_i,
  input  logic                 tick_i,
  input  logic                 read_i,
  output logic [LO_W+HI_W-1:0] ts_o,
  output logic                 ts_valid_o
);
  localparam int TS_W = LO_W + HI_W;

  logic            strobe_w;
  logic [LO_W-1:0] sample_w;
  logic            wrap_w;
  logic [HI_W-1:0] hi_q;
  logic [HI_W-1:0] hi_next_w;
  logic [TS_W-1:0] ts_q;
  logic            valid_q;

  ctr_extend_strobe #(.LO_W(LO_W), .N_SRC(2)) u_strobe (
    .src_i   ({read_i, tick_i}),
    .armed_i (armed_i),
    .cnt_i   (cnt_i),
    .strobe_o(strobe_w),
    .sample_o(sample_w)
  );

  ctr_extend_wrap #(.LO_W(LO_W)) u_wrap (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe_i(strobe_w),
    .sample_i(sample_w),
    .wrap_o  (wrap_w)
  );

  ctr_extend_high #(.HI_W(HI_W)) u_high (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_i   (wrap_w),
    .hi_q_o   (hi_q),
    .hi_next_o(hi_next_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= strobe_w;
      if (strobe_w) ts_q <= {hi_next_w, sample_w};
    end
  end

  assign ts_o       = ts_q;
  assign ts_valid_o = valid_q;
endmodule

// File: rtl/ctr_extend_checker.sv
module ctr_extend_checker #(
  parameter int LO_W = 32,
  parameter int HI_W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LO_W-1:0]      cnt_i,
  input logic                 armed_i,
  input logic                 tick_i,
  input logic                 read_i,
  input logic [LO_W+HI_W-1:0] ts_o,
  input logic                 ts_valid_o,
  input logic                 wrap_w,
  input logic [HI_W-1:0]      hi_q
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i || read_i) |=> ts_valid_o);

  assert_low_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick_i || read_i) && armed_i) |=> (ts_o[LO_W-1:0] == $past(cnt_i)));

  assert_unarmed_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((tick_i || read_i) && !armed_i) |=> (ts_o[LO_W-1:0] == '0));

  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_w |=> (hi_q == $past(hi_q) + 1'b1));

  assert_hold_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_w |=> $stable(hi_q));

  assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_i || read_i) |=> (!ts_valid_o && $stable(ts_o)));

  assert_upper_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ts_valid_o |-> (ts_o[LO_W+HI_W-1:LO_W] == hi_q));
endmodule

bind ctr_extend ctr_extend_checker #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_i     (cnt_i),
  .armed_i   (armed_i),
  .tick_i    (tick_i),
  .read_i    (read_i),
  .ts_o      (ts_o),
  .ts_valid_o(ts_valid_o),
  .wrap_w    (wrap_w),
  .hi_q      (hi_q)
);

// File: tb/test_ctr_extend.sv
module test_ctr_extend;
  localparam int LO_W = 4;
  localparam int HI_W = 4;
  localparam int TS_W = LO_W + HI_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [LO_W-1:0] cnt_i = '0;
  logic            armed_i = 1'b0;
  logic            tick_i = 1'b0;
  logic            read_i = 1'b0;
  logic [TS_W-1:0] ts_o;
  logic            ts_valid_o;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model
  int m_prev = 0;
  int m_have = 0;
  int m_hi = 0;

  always #10 clk = ~clk;

  ctr_extend #(.LO_W(LO_W), .HI_W(HI_W)) i_ctr_extend (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .armed_i(armed_i),
    .tick_i(tick_i), .read_i(read_i), .ts_o(ts_o), .ts_valid_o(ts_valid_o)
  );

  task automatic check(string req, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_i = 0; read_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_prev = 0; m_have = 0; m_hi = 0;
    check("R4 reset ts", int'(ts_o), 0);
    check("R4 reset valid", int'(ts_valid_o), 0);
  endtask

  // Drives one strobe at a negedge, checks the result at the next negedge.
  task automatic strobe(bit tk, bit rd, bit arm, int val, string req);
    int eff;
    eff = arm ? val : 0;
    if (m_have != 0 && m_prev > eff) m_hi = (m_hi + 1) % (1 << HI_W);
    m_prev = eff; m_have = 1;
    cnt_i = LO_W'(val); armed_i = arm; tick_i = tk; read_i = rd;
    @(negedge clk);
    tick_i = 0; read_i = 0;
    check({req, " valid"}, int'(ts_valid_o), 1);
    check({req, " ts"}, int'(ts_o), (m_hi << LO_W) | eff);
  endtask

  task automatic idle(int n);
    logic [TS_W-1:0] held;
    held = ts_o;
    cnt_i = ~cnt_i;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R8 idle valid", int'(ts_valid_o), 0);
      check("R8 idle hold", int'(ts_o), int'(held));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4: first sample after reset, small value, no increment
    strobe(1, 0, 1, 3, "R4 first");
    strobe(0, 1, 1, 1, "R2 wrap after first");
    // R2/R3/R5/R9: all ordered pairs, continuous
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        strobe(1, 0, 1, a, "R3 pair a");
        strobe(0, 1, 1, b, "R2 pair b");
      end
    end
    idle(3);
    // R6: both strobes in one cycle, with a wrap
    strobe(1, 1, 1, 12, "R6 merged setup");
    strobe(1, 1, 1, 2, "R6 merged wrap");
    strobe(1, 1, 1, 2, "R6 merged equal");
    idle(2);
    // R7: unarmed samples read 0 and store 0
    strobe(0, 1, 1, 9, "R7 armed setup");
    strobe(0, 1, 0, 9, "R7 unarmed wrap");
    strobe(1, 0, 0, 5, "R7 unarmed again");
    strobe(1, 0, 1, 5, "R7 after arm");
    // R4: first sample after a fresh reset with a large value
    do_reset();
    strobe(1, 0, 1, 15, "R4 first large");
    strobe(1, 0, 1, 0, "R9 wrap from 15");
    // R9: drive upper word through its maximum
    for (int k = 0; k < 17; k++) begin
      strobe(1, 0, 1, 8, "R9 climb hi");
      strobe(0, 1, 1, 0, "R9 climb wrap");
    end
    idle(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule